// File: doc/BRIEF.md
# Protection-Aware Image Checksum Engine

This block computes the 16-bit verification checksum of a small program image that sits behind a read port. A single start pulse launches one pass. The engine first fetches the configuration word. Bit 3 of that word selects the protection mode. The engine then walks the addresses it needs, adds every returned word into a 16-bit running total, and raises a one-cycle done flag when the total is final.

When protection is off, the total covers the whole readable program range. When protection is on, the total covers only the small block at the bottom of memory, plus a 16-bit value built from the low nibbles of the four identification words. In both modes the configuration word is masked down to its five low bits before it is added.

The read port is a valid/ready request channel carrying an address. It is followed by a response that always arrives exactly one cycle after each accepted request. The request side honours back-pressure: an offered address stays put until ready is seen. The response side has no ready, because the engine absorbs one word per cycle.

Top module: `image_checksum`

## Requirements
- R1: After reset, done is 0, req_valid is 0 and checksum is 0x0000.
- R2: A start pulse while idle clears the total, and the first accepted request is the configuration address 0x3FF.
- R3: Configuration bit 3 equal to 0 selects protected mode; equal to 1 selects unprotected mode.
- R4: In unprotected mode, requests after the configuration word cover 0x000 to 0x1FE ascending, each once, and the result is their sum plus (config AND 0x01F). A fully blank image (every word 0xFFF, config 0xFFF) yields 0xEE20.
- R5: In protected mode, requests after the configuration word are 0x200..0x203 and then 0x000..0x03F ascending. The result is their data sum plus (config AND 0x01F) plus the packed ID value, in which the ID at 0x200 supplies bits 15:12 and the ID at 0x203 supplies bits 3:0.
- R6: All additions wrap at 16 bits; only the low 16 bits of the total are reported.
- R7: While req_valid is high and req_ready is low, req_valid stays high and req_addr does not change. Exactly one response is consumed per accepted request, one cycle later.
- R8: done is high for exactly one cycle per pass, the checksum is valid in that cycle, and it holds until the next start.
- R9: A start pulse while a pass is in progress is ignored: the pass completes with the same result and only one done pulse.
- R10: Only bits 3:0 of each ID word and bits 4:0 of the configuration word affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a pass when idle |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Memory accepts the offered request |
| req_addr | output | 10 | Word address of the read request |
| rsp_valid | input | 1 | Read data present, one cycle after an accepted request |
| rsp_data | input | 12 | Read data word |
| done | output | 1 | One-cycle pulse marking a final checksum |
| checksum | output | 16 | Accumulated checksum |

## Verification
The assertions assume that the memory returns rsp_valid only in the cycle after a request handshake, and never otherwise. The bench memory model guarantees this by answering each accepted request on the following edge and holding rsp_valid low in all other cycles. The assertions also assume that start is a clean synchronous pulse. The bench drives start on falling edges for whole cycles, including one pulse placed deliberately inside a running pass. Ready is either tied high or toggled pseudo-randomly, so both streaming and stalled request traffic stay within the handshake rules.

// File: rtl/ck_pkg.sv
package ck_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CFG,
    PH_CFG_WAIT,
    PH_ID,
    PH_MAIN,
    PH_DRAIN,
    PH_FIN
  } ck_state_e;

  typedef enum logic [1:0] {
    TAG_CFG,
    TAG_ID,
    TAG_MAIN
  } ck_tag_e;

endpackage

// File: rtl/ck_addr_seq.sv
module ck_addr_seq
  import ck_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ID_COUNT = 4,
  parameter int IDX_W    = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 10'h3FF,
  parameter logic [ADDR_W-1:0] ID_BASE   = 10'h200,
  parameter logic [ADDR_W-1:0] PROT_LAST = 10'h03F,
  parameter logic [ADDR_W-1:0] FULL_LAST = 10'h1FE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              cfg_cp_bit,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              clear,
  output ck_tag_e           rsp_tag,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              done
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_COUNT - 1);

  ck_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              prot_q, prot_d;
  ck_tag_e           cur_tag;
  logic              fire;
  logic [ADDR_W-1:0] last_addr;

  assign last_addr = prot_q ? PROT_LAST : FULL_LAST;
  assign fire      = req_valid & req_ready;

  always_comb begin
    req_valid = 1'b0;
    req_addr  = '0;
    cur_tag   = TAG_MAIN;
    unique case (state_q)
      PH_CFG: begin
        req_valid = 1'b1;
        req_addr  = CFG_ADDR;
        cur_tag   = TAG_CFG;
      end
      PH_ID: begin
        req_valid = 1'b1;
        req_addr  = ID_BASE + {{(ADDR_W-IDX_W){1'b0}}, idx_q};
        cur_tag   = TAG_ID;
      end
      PH_MAIN: begin
        req_valid = 1'b1;
        req_addr  = ptr_q;
        cur_tag   = TAG_MAIN;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    prot_d  = prot_q;
    clear   = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          clear   = 1'b1;
          state_d = PH_CFG;
        end
      end
      PH_CFG: begin
        if (fire) state_d = PH_CFG_WAIT;
      end
      PH_CFG_WAIT: begin
        if (rsp_valid) begin
          prot_d = ~cfg_cp_bit;
          ptr_d  = '0;
          idx_d  = '0;
          state_d = cfg_cp_bit ? PH_MAIN : PH_ID;
        end
      end
      PH_ID: begin
        if (fire) begin
          if (idx_q == IDX_LAST) state_d = PH_MAIN;
          else idx_d = idx_q + 1'b1;
        end
      end
      PH_MAIN: begin
        if (fire) begin
          if (ptr_q == last_addr) state_d = PH_DRAIN;
          else ptr_d = ptr_q + 1'b1;
        end
      end
      PH_DRAIN: begin
        if (rsp_valid) state_d = PH_FIN;
      end
      PH_FIN: begin
        done    = 1'b1;
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      prot_q  <= 1'b0;
      rsp_tag <= TAG_CFG;
      rsp_idx <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      prot_q  <= prot_d;
      if (fire) begin
        rsp_tag <= cur_tag;
        rsp_idx <= idx_q;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R7
  AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(fire)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) && (state_q != PH_CFG) && start |=> state_q != PH_CFG); // R9
  AST_MAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cur_tag == TAG_MAIN) |-> req_addr <= (prot_q ? PROT_LAST : FULL_LAST)); // R4

endmodule

// File: rtl/ck_accum.sv
module ck_accum
  import ck_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SUM_W    = 16,
  parameter int NIB_W    = 4,
  parameter int ID_COUNT = 4,
  parameter int IDX_W    = 2,
  parameter logic [DATA_W-1:0] CFG_MASK = 12'h01F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  ck_tag_e           rsp_tag,
  input  logic [IDX_W-1:0]  rsp_idx,
  output logic [SUM_W-1:0]  sum
);

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] word_ext;
  logic [SUM_W-1:0] cfg_ext;
  logic [SUM_W-1:0] nib_ext;
  logic [SUM_W-1:0] id_lane [ID_COUNT];
  logic [SUM_W-1:0] term;

  assign word_ext = {{(SUM_W-DATA_W){1'b0}}, rsp_data};
  assign cfg_ext  = {{(SUM_W-DATA_W){1'b0}}, rsp_data & CFG_MASK};
  assign nib_ext  = {{(SUM_W-NIB_W){1'b0}}, rsp_data[NIB_W-1:0]};

  for (genvar g = 0; g < ID_COUNT; g++) begin : g_id_lane
    assign id_lane[g] = nib_ext << (NIB_W * (ID_COUNT - 1 - g));
  end

  always_comb begin
    unique case (rsp_tag)
      TAG_CFG: term = cfg_ext;
      TAG_ID:  term = id_lane[rsp_idx];
      default: term = word_ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sum_q <= '0;
    else if (clear)      sum_q <= '0;
    else if (rsp_valid)  sum_q <= sum_q + term;
  end

  assign sum = sum_q;

  AST_CFG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_tag == TAG_CFG) |-> sum_q == '0); // R2

endmodule

// File: rtl/image_checksum.sv
module image_checksum
  import ck_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 12,
  parameter int SUM_W    = 16,
  parameter int NIB_W    = 4,
  parameter int ID_COUNT = 4,
  parameter int CP_BIT   = 3,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 10'h3FF,
  parameter logic [ADDR_W-1:0] ID_BASE   = 10'h200,
  parameter logic [ADDR_W-1:0] PROT_LAST = 10'h03F,
  parameter logic [ADDR_W-1:0] FULL_LAST = 10'h1FE,
  parameter logic [DATA_W-1:0] CFG_MASK  = 12'h01F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [SUM_W-1:0]  checksum
);

  localparam int IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;

  logic             clear;
  ck_tag_e          rsp_tag;
  logic [IDX_W-1:0] rsp_idx;

  ck_addr_seq #(
    .ADDR_W   (ADDR_W),
    .ID_COUNT (ID_COUNT),
    .IDX_W    (IDX_W),
    .CFG_ADDR (CFG_ADDR),
    .ID_BASE  (ID_BASE),
    .PROT_LAST(PROT_LAST),
    .FULL_LAST(FULL_LAST)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .cfg_cp_bit(rsp_data[CP_BIT]),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .clear     (clear),
    .rsp_tag   (rsp_tag),
    .rsp_idx   (rsp_idx),
    .done      (done)
  );

  ck_accum #(
    .DATA_W  (DATA_W),
    .SUM_W   (SUM_W),
    .NIB_W   (NIB_W),
    .ID_COUNT(ID_COUNT),
    .IDX_W   (IDX_W),
    .CFG_MASK(CFG_MASK)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_tag  (rsp_tag),
    .rsp_idx  (rsp_idx),
    .sum      (checksum)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(checksum)); // R8
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !rsp_valid); // R8

endmodule

// File: tb/image_checksum_tb.sv
`timescale 1ns/1ps
module image_checksum_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [9:0]  req_addr;
  logic        rsp_valid = 1'b0;
  logic [11:0] rsp_data = '0;
  logic        done;
  logic [15:0] checksum;

  logic [11:0] mem [1024];
  int n_checks = 0;
  int n_fail = 0;
  bit stall_mode = 0;
  bit exp_prot = 0;
  int seq_k = 0;
  int order_err = 0;
  int hold_err = 0;
  int done_cnt = 0;
  bit hold_pend = 0;
  logic [9:0] prev_addr = '0;

  always #2 clk = ~clk;

  image_checksum u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .checksum(checksum)
  );

  function automatic int exp_addr(int k, bit prot);
    if (k == 0) return 'h3FF;
    if (prot) return (k <= 4) ? ('h200 + k - 1) : (k - 5);
    return k - 1;
  endfunction

  function automatic logic [15:0] model_sum();
    int s;
    int last;
    logic [11:0] cfg;
    cfg = mem[1023];
    s = cfg & 'h1F;
    if (!cfg[3]) begin
      last = 'h3F;
      s += ((mem['h200] & 'hF) << 12) | ((mem['h201] & 'hF) << 8)
         | ((mem['h202] & 'hF) << 4) | (mem['h203] & 'hF);
    end else begin
      last = 'h1FE;
    end
    for (int a = 0; a <= last; a++) s += mem[a];
    return s[15:0];
  endfunction

  // memory model, ready pattern and protocol monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      hold_pend <= 1'b0;
      seq_k     <= 0;
    end else begin
      rsp_valid <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        rsp_data <= mem[req_addr];
        if (int'(req_addr) != exp_addr(seq_k, exp_prot)) order_err++;
        seq_k <= seq_k + 1;
      end
      if (hold_pend && !(req_valid && req_addr == prev_addr)) hold_err++;
      hold_pend <= req_valid && !req_ready;
      prev_addr <= req_addr;
      req_ready <= stall_mode ? ($urandom % 3 != 0) : 1'b1;
      if (done) begin
        done_cnt++;
        seq_k <= 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic fill(int mode);
    for (int a = 0; a < 1024; a++)
      mem[a] = (mode == 0) ? 12'hFFF : 12'($urandom);
  endtask

  task automatic run_case(logic [11:0] cfg, bit stall, bit restart, string req,
                          int literal, bit use_lit);
    logic [15:0] expv;
    logic [15:0] got;
    int d0, o0, h0, cyc;
    mem[1023] = cfg;
    exp_prot = !cfg[3];
    stall_mode = stall;
    expv = model_sum();
    d0 = done_cnt; o0 = order_err; h0 = hold_err;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      start = (restart && cyc == 40);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc < 5000, {req, " done seen"}, cyc, 5000);
    got = checksum;
    check(got == expv, {req, " checksum"}, got, expv);
    if (use_lit) check(got == 16'(literal), {req, " known value"}, got, literal);
    @(negedge clk);
    check(!done && checksum == got, "R8 pulse and hold", {done, checksum}, {1'b0, got});
    check(done_cnt - d0 == 1, "R8 R9 single done", done_cnt - d0, 1);
    check(order_err == o0, "R2 R4 R5 address order", order_err - o0, 0);
    check(hold_err == h0, "R7 request hold", hold_err - h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(done == 0, "R1 done", done, 0);
    check(req_valid == 0, "R1 req_valid", req_valid, 0);
    check(checksum == 0, "R1 checksum", checksum, 0);

    // R4 blank, unprotected
    fill(0);
    run_case(12'hFFF, 0, 0, "R4 blank", 'hEE20, 1);
    // R6 wrap with 0x723 at bottom and top of range
    mem[0] = 12'h723; mem['h1FE] = 12'h723;
    run_case(12'hFFF, 0, 0, "R6 sparse words", 0, 0);
    // R7 stalls on the request side
    fill(0);
    run_case(12'hFFF, 1, 0, "R7 stalled blank", 'hEE20, 1);
    // R5 protected, IDs 1..4 with upper bits set (R10)
    mem['h200] = 12'hFF1; mem['h201] = 12'hFF2;
    mem['h202] = 12'hFF3; mem['h203] = 12'hFF4;
    run_case(12'hFF7, 0, 0, "R5 R10 protected ids", 'h120B, 1);
    // R9 restart pulse mid-pass
    fill(1);
    run_case(12'hFFF, 1, 1, "R9 restart unprot", 0, 0);
    run_case(12'h7F0, 0, 1, "R9 restart prot", 0, 0);
    // R3 R10 sweep over all low config bit patterns
    for (int c = 0; c < 32; c++) begin
      fill(1);
      run_case({7'($urandom), 5'(c)}, c[0], 0, "R3 R10 cfg sweep", 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule